// File: doc/BRIEF.md
# DMA Transfer Count and Interrupt Unit

This block holds the two byte counters of a bus-master DMA engine, one for each direction (write toward the bus, read from the bus), and the interrupt status that goes with them. Software loads a byte count through a small register port. While a direction's enable input is high and its count is nonzero, the block raises that direction's request output. Each completed data beat lowers the count by the bytes the beat carried. A direction finishes when its count reaches zero.

The bus protocol engine reports bus errors on an abort strobe. Completion events and aborts set sticky status bits. Software clears a status bit by writing a one to it. A single interrupt output combines every status bit that is both set and enabled. Count checking can be switched off. The counters then freeze, and the requests follow the enable inputs alone.

Top module: `dma_xfer_count`

## Requirements
- R1: After reset both counts, the control register and the status register read zero, and `wr_req`, `rd_req` and `irq` are low.
- R2: Register port map: address 0 is the write-direction count, address 1 the read-direction count, address 2 control, address 3 status. A count accepts any value, including values that are not multiples of four. Bits above CNT_W are dropped. Reads are combinational on `reg_addr`, and a count register reads back the bytes still to move.
- R3: With count checking on, a beat strobe with a nonzero count lowers the count by the beat's byte number (1 to 4). If fewer bytes remain than the beat carries, the count is clipped to zero and never wraps. A beat that arrives with a zero count is ignored.
- R4: With count checking on, a request output is high exactly when its enable input is high and its count is nonzero. Writing a nonzero count while enabled therefore starts a transfer.
- R5: Status bit 18 (write done) or bit 19 (read done) is set at the same clock edge at which that count reaches zero through a beat. The request then stays low until a new nonzero count is written. Writing a zero count does not set a done bit.
- R6: Control bit 3 enables count checking. When it is clear, beats leave the counts unchanged, no done bit is set, and each request simply follows its enable input.
- R7: An `bus_abort` pulse sets status bit 21, whatever the count or enable state.
- R8: Writing status with a one in bits 18, 19 or 21 clears those bits. Zeros leave bits unchanged. A set event in the same cycle wins over the clear.
- R9: Control bits 0, 1 and 2 enable the write-done, read-done and abort interrupts. The abort interrupt is also enabled whenever bit 0 or bit 1 is set. `irq` is the OR of all set-and-enabled status bits.
- R10: When a software count write and a beat on the same direction meet in one cycle, the written value is kept and the beat is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| wr_en | input | 1 | Write-direction master enable |
| rd_en | input | 1 | Read-direction master enable |
| wr_beat | input | 1 | Write-direction beat complete |
| wr_beat_bytes | input | 3 | Bytes moved by the write beat (1 to 4) |
| rd_beat | input | 1 | Read-direction beat complete |
| rd_beat_bytes | input | 3 | Bytes moved by the read beat (1 to 4) |
| bus_abort | input | 1 | Master or target abort strobe |
| wr_req | output | 1 | Write-direction transfer request |
| rd_req | output | 1 | Read-direction transfer request |
| irq | output | 1 | Interrupt output |

## Verification
The bench builds the block with CNT_W set to 10, so a write of 0x7FF lands as 0x3FF and shows the upper bits being dropped. Counts of 5, 7 and 9 bytes are short enough to make the clipped last beat and the zero crossing appear within a few cycles. A behavioural model tracks both counts, the control register and the status register, and compares the requests, the interrupt and the read data on every clock. The stimulus includes collisions of a beat with a count write, and of a done event with a status clear.

// File: rtl/dma_xfer_count.sv
module dma_xfer_count #(
  parameter int CNT_W = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic        wr_beat,
  input  logic [2:0]  wr_beat_bytes,
  input  logic        rd_beat,
  input  logic [2:0]  rd_beat_bytes,
  input  logic        bus_abort,
  output logic        wr_req,
  output logic        rd_req,
  output logic        irq
);
  localparam logic [1:0] A_WCNT = 2'd0;
  localparam logic [1:0] A_RCNT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;
  localparam int B_WDONE = 18;
  localparam int B_RDONE = 19;
  localparam int B_ABORT = 21;

  logic [CNT_W-1:0] wcnt, rcnt;
  logic [3:0]       ctrl;
  logic             st_wdone, st_rdone, st_abort;

  wire chk_on  = ctrl[3];
  wire sel_w   = reg_wr && reg_addr == A_WCNT;
  wire sel_r   = reg_wr && reg_addr == A_RCNT;
  wire sel_c   = reg_wr && reg_addr == A_CTRL;
  wire sel_s   = reg_wr && reg_addr == A_STAT;

  wire [CNT_W-1:0] wbytes = CNT_W'(wr_beat_bytes);
  wire [CNT_W-1:0] rbytes = CNT_W'(rd_beat_bytes);

  wire w_step = chk_on && wr_beat && !sel_w && wcnt != '0;
  wire r_step = chk_on && rd_beat && !sel_r && rcnt != '0;
  wire w_last = w_step && wbytes >= wcnt;
  wire r_last = r_step && rbytes >= rcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= '0;
      rcnt <= '0;
      ctrl <= '0;
    end else begin
      if (sel_w)       wcnt <= reg_wdata[CNT_W-1:0];
      else if (w_last) wcnt <= '0;
      else if (w_step) wcnt <= wcnt - wbytes;

      if (sel_r)       rcnt <= reg_wdata[CNT_W-1:0];
      else if (r_last) rcnt <= '0;
      else if (r_step) rcnt <= rcnt - rbytes;

      if (sel_c) ctrl <= reg_wdata[3:0];
    end
  end

  wire clr_w = sel_s && reg_wdata[B_WDONE];
  wire clr_r = sel_s && reg_wdata[B_RDONE];
  wire clr_a = sel_s && reg_wdata[B_ABORT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_wdone <= 1'b0;
      st_rdone <= 1'b0;
      st_abort <= 1'b0;
    end else begin
      st_wdone <= (st_wdone && !clr_w) || w_last;
      st_rdone <= (st_rdone && !clr_r) || r_last;
      st_abort <= (st_abort && !clr_a) || bus_abort;
    end
  end

  logic [31:0] stat_word;
  always_comb begin
    stat_word = '0;
    stat_word[B_WDONE] = st_wdone;
    stat_word[B_RDONE] = st_rdone;
    stat_word[B_ABORT] = st_abort;
  end

  always_comb begin
    unique case (reg_addr)
      A_WCNT:  reg_rdata = 32'(wcnt);
      A_RCNT:  reg_rdata = 32'(rcnt);
      A_CTRL:  reg_rdata = 32'(ctrl);
      default: reg_rdata = stat_word;
    endcase
  end

  wire abort_ie = ctrl[2] || ctrl[1] || ctrl[0];

  assign wr_req = wr_en && (!chk_on || wcnt != '0);
  assign rd_req = rd_en && (!chk_on || rcnt != '0);
  assign irq    = (st_wdone && ctrl[0]) || (st_rdone && ctrl[1]) || (st_abort && abort_ie);
endmodule

module dma_xfer_count_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             wr_beat,
  input logic [2:0]       wr_beat_bytes,
  input logic             bus_abort,
  input logic             wr_en,
  input logic             wr_req,
  input logic             irq,
  input logic [CNT_W-1:0] wcnt,
  input logic [3:0]       ctrl,
  input logic             st_wdone,
  input logic             st_rdone,
  input logic             st_abort
);
  wire w_move = ctrl[3] && wr_beat && !(reg_wr && reg_addr == 2'd0) && wcnt != '0;

  // R3
  count_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_move |=> wcnt < $past(wcnt));

  // R5
  wdone_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_move && CNT_W'(wr_beat_bytes) >= wcnt) |=> st_wdone && wcnt == '0);

  // R4
  wreq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> wr_en);

  // R7
  abort_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_abort |=> st_abort);

  // R8
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd3 && reg_wdata[21] && !bus_abort) |=> !st_abort);

  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st_wdone || st_rdone || st_abort));
endmodule

bind dma_xfer_count dma_xfer_count_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .wr_beat(wr_beat), .wr_beat_bytes(wr_beat_bytes),
  .bus_abort(bus_abort), .wr_en(wr_en), .wr_req(wr_req), .irq(irq),
  .wcnt(wcnt), .ctrl(ctrl), .st_wdone(st_wdone), .st_rdone(st_rdone),
  .st_abort(st_abort)
);

// File: tb/dma_xfer_count_bench.sv
module dma_xfer_count_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic wr_en = 0, rd_en = 0, wr_beat = 0, rd_beat = 0, bus_abort = 0;
  logic [2:0] wr_beat_bytes = 0, rd_beat_bytes = 0;
  logic wr_req, rd_req, irq;

  int errors = 0, checks = 0;

  dma_xfer_count #(.CNT_W(CW)) u_dma_xfer_count (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_en(wr_en), .rd_en(rd_en),
    .wr_beat(wr_beat), .wr_beat_bytes(wr_beat_bytes), .rd_beat(rd_beat),
    .rd_beat_bytes(rd_beat_bytes), .bus_abort(bus_abort), .wr_req(wr_req),
    .rd_req(rd_req), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  int m_w, m_r, m_ctrl;
  bit m_s18, m_s19, m_s21;
  localparam int MASK = (1 << CW) - 1;

  always @(posedge clk) begin
    int nw, nr;
    bit set18, set19;
    if (!rst_n) begin
      m_w = 0; m_r = 0; m_ctrl = 0; m_s18 = 0; m_s19 = 0; m_s21 = 0;
    end else begin
      nw = m_w; nr = m_r; set18 = 0; set19 = 0;
      if (reg_wr && reg_addr == 0) nw = reg_wdata & MASK;
      else if (m_ctrl[3] && wr_beat && m_w > 0) begin
        nw = (wr_beat_bytes >= m_w) ? 0 : m_w - wr_beat_bytes;
        set18 = (nw == 0);
      end
      if (reg_wr && reg_addr == 1) nr = reg_wdata & MASK;
      else if (m_ctrl[3] && rd_beat && m_r > 0) begin
        nr = (rd_beat_bytes >= m_r) ? 0 : m_r - rd_beat_bytes;
        set19 = (nr == 0);
      end
      if (reg_wr && reg_addr == 3) begin
        if (reg_wdata[18]) m_s18 = 0;
        if (reg_wdata[19]) m_s19 = 0;
        if (reg_wdata[21]) m_s21 = 0;
      end
      if (set18) m_s18 = 1;
      if (set19) m_s19 = 1;
      if (bus_abort) m_s21 = 1;
      if (reg_wr && reg_addr == 2) m_ctrl = reg_wdata & 15;
      m_w = nw; m_r = nr;
    end
  end

  function automatic logic [31:0] exp_rdata(input logic [1:0] a);
    case (a)
      2'd0: return 32'(m_w);
      2'd1: return 32'(m_r);
      2'd2: return 32'(m_ctrl);
      default: return (32'(m_s18) << 18) | (32'(m_s19) << 19) | (32'(m_s21) << 21);
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    bit ew, er, ei;
    ew = wr_en && (!m_ctrl[3] || m_w != 0);
    er = rd_en && (!m_ctrl[3] || m_r != 0);
    ei = (m_s18 && m_ctrl[0]) || (m_s19 && m_ctrl[1]) || (m_s21 && (m_ctrl & 7) != 0);
    check(wr_req === ew, "R4 wr_req", 32'(wr_req), 32'(ew));
    check(rd_req === er, "R4 rd_req", 32'(rd_req), 32'(er));
    check(irq === ei, "R9 irq", 32'(irq), 32'(ei));
    check(reg_rdata === exp_rdata(reg_addr), "R2 rdata", reg_rdata, exp_rdata(reg_addr));
  end

  task automatic cyc(); @(posedge clk); #1; endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cyc(); reg_wr = 1; reg_addr = a; reg_wdata = d;
    cyc(); reg_wr = 0;
  endtask

  task automatic expect_reg(input logic [1:0] a, input logic [31:0] e, input string tag);
    reg_addr = a;
    @(negedge clk);
    check(reg_rdata === e, tag, reg_rdata, e);
    cyc();
  endtask

  task automatic wbeat(input int n);
    wr_beat = 1; wr_beat_bytes = 3'(n); cyc(); wr_beat = 0;
  endtask

  task automatic rbeat(input int n);
    rd_beat = 1; rd_beat_bytes = 3'(n); cyc(); rd_beat = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(); cyc(); rst_n = 1; cyc();
    // R1
    expect_reg(0, 0, "R1 wcnt reset");
    expect_reg(1, 0, "R1 rcnt reset");
    expect_reg(2, 0, "R1 ctrl reset");
    expect_reg(3, 0, "R1 status reset");
    check(!wr_req && !rd_req && !irq, "R1 outputs", {wr_req, rd_req, irq}, 0);

    // R2 R4 R3 R5
    wr(2, 32'h9);
    wr(0, 7);
    expect_reg(0, 7, "R2 wcnt load 7");
    check(!wr_req, "R4 req low while disabled", 32'(wr_req), 0);
    wr_en = 1; cyc();
    check(wr_req, "R4 req starts", 32'(wr_req), 1);
    wbeat(4);
    expect_reg(0, 3, "R3 count after 4 bytes");
    wbeat(4);
    expect_reg(0, 0, "R3 clipped to zero");
    expect_reg(3, 32'h40000, "R5 write done bit18");
    check(!wr_req && irq, "R5 req drops irq rises", {wr_req, irq}, 2'b01);
    wbeat(2);
    expect_reg(0, 0, "R3 beat at zero ignored");
    wr(0, 0);
    check(!wr_req, "R5 zero write keeps req low", 32'(wr_req), 0);

    // R7 R8 R9
    bus_abort = 1; cyc(); bus_abort = 0;
    expect_reg(3, 32'h240000, "R7 abort bit21");
    wr(3, 32'h40000);
    expect_reg(3, 32'h200000, "R8 clear bit18 only");
    check(irq, "R9 abort irq auto-enabled", 32'(irq), 1);
    wr(3, 0);
    expect_reg(3, 32'h200000, "R8 zero write no effect");
    wr(3, 32'h200000);
    check(!irq, "R9 irq clears", 32'(irq), 0);
    wr(2, 32'h8);
    bus_abort = 1; cyc(); bus_abort = 0;
    check(!irq, "R9 abort masked", 32'(irq), 0);
    wr(3, 32'h200000);

    // read direction
    wr(2, 32'hA);
    rd_en = 1;
    wr(1, 5);
    rbeat(2); rbeat(2);
    expect_reg(1, 1, "R3 read count 1");
    rbeat(1);
    expect_reg(3, 32'h80000, "R5 read done bit19");

    // R10 collision
    wr(1, 3);
    rd_beat = 1; rd_beat_bytes = 3'd2;
    reg_wr = 1; reg_addr = 1; reg_wdata = 9; cyc();
    reg_wr = 0; rd_beat = 0;
    expect_reg(1, 9, "R10 sw write wins");

    // R8 set wins over clear
    wr(1, 1);
    rd_beat = 1; rd_beat_bytes = 3'd1;
    reg_wr = 1; reg_addr = 3; reg_wdata = 32'h80000; cyc();
    reg_wr = 0; rd_beat = 0;
    expect_reg(3, 32'h80000, "R8 set wins clear");
    wr(3, 32'h80000);
    rd_en = 0;

    // R6 checking off
    wr(2, 32'h1);
    wr(0, 3);
    wbeat(2); wbeat(4);
    expect_reg(0, 3, "R6 count frozen");
    expect_reg(3, 0, "R6 no done");
    check(wr_req, "R6 req follows enable", 32'(wr_req), 1);
    wr_en = 0; cyc();
    check(!wr_req, "R6 req low", 32'(wr_req), 0);

    // R2 truncation
    wr(0, 32'h7FF);
    expect_reg(0, 32'h3FF, "R2 upper bits dropped");

    cyc(); cyc();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule